// File: doc/BRIEF.md
# SDRAM Refresh Timer and Sequencer

This block keeps SDRAM contents alive without help from software once it has been set up. A free-running prescaler, with a division ratio chosen by a 3-bit select code, drives an 8-bit interval counter. The counter is compared with a programmable limit on every clock. When they match, the counter returns to zero and a refresh request is raised. The request waits until the surrounding memory controller reports an idle bus. It then starts a short sequence: one lead cycle, the auto-refresh command, and a lockout of NOP cycles. The lockout length is a fixed base plus two programmable counts for RAS time and row-cycle time.

A mode register holds an enable bit and a mode bit. With the enable bit set and the mode bit clear, periodic auto-refresh runs. With both bits set, the block puts the memory into self-refresh by issuing the refresh command with CKE low, and holds CKE low until the mode changes. On exit, CKE goes high and NOP is driven for the row-cycle count before the block reports ready. A separate controller sequences normal reads and writes, and uses the busy output to keep off the command bus.

Top module: `sdram_refresh_ctl`

## Requirements
- R1: After reset the command pins carry NOP (cs_n,ras_n,cas_n,we_n = 0111), CKE is high and busy is low.
- R2: Timer requests lead to refresh commands only when register address 0 has bit 0 (enable) = 1 and bit 1 (mode) = 0. With the enable bit at 0, no refresh command appears.
- R3: Clock-select code (address 3, bits 2:0) values 1..7 divide the clock by 4, 16, 64, 256, 1024, 2048 and 4096. Code 0 stops the counter. Each write to this register restarts the divider phase from zero.
- R4: Writing a nonzero clock select does not clear the counter. Counting continues from the value last written at address 2 and wraps from 255 to 0.
- R5: When the counter equals the compare value (address 1), the counter is cleared and a request is raised in the same step. Successive refresh commands are therefore ratio × compare cycles apart.
- R6: A pending request starts a sequence only while bus_idle is high. A pending request is a single flag, so repeated matches while it waits produce one refresh.
- R7: A refresh sequence drives one NOP cycle with busy high, then the refresh command 0001 with CKE high on its second cycle.
- R8: After the refresh command, NOP with busy high is held for 1 + RAS count (address 0 bits 4:2) + row count (address 0 bits 7:5) cycles. Busy then falls.
- R9: With enable and mode bits both 1 and bus_idle high, the block issues 0001 with CKE low, then holds NOP with CKE low and busy high.
- R10: Clearing the mode bit in self-refresh raises CKE, then holds NOP and busy for the row-count cycles before busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 mode, 1 compare, 2 counter, 3 clock select |
| cfg_wdata | input | 8 | Register write data |
| bus_idle | input | 1 | High when the command bus may be taken |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_cke | output | 1 | SDRAM clock enable |
| rfsh_busy | output | 1 | High while a refresh or self-refresh sequence owns the bus |

## Verification
The bench starts the counter above the compare value so the count must wrap. A design that cleared the counter on a clock-select write would then refresh far too early. It holds bus_idle low across three matches and expects exactly one refresh two cycles after release: a queued request would refresh twice back to back, and a design that ignored bus_idle would refresh at once. It measures the lockout and the self-refresh exit length for nonzero RAS and row counts, which catches a lockout that drops one of the terms. It also checks that select code 0 and a cleared enable bit leave the command pins at NOP.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_REF, ST_HOLD, ST_SR_ENTRY, ST_SR_ACTIVE, ST_SR_EXIT
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_REF = 4'b0001;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;
  localparam logic [1:0] ADDR_CLK  = 2'd3;

  typedef struct packed {
    logic [2:0] row_cyc;
    logic [2:0] ras_cyc;
    logic       self_mode;
    logic       ref_en;
  } mode_t;

  // log2 of the division ratio for each select code
  function automatic int unsigned div_shift(input logic [2:0] sel);
    case (sel)
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      3'd6:    return 11;
      3'd7:    return 12;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler
  import sdram_refresh_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       restart,
  output logic       tick
);

  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] div_q, div_d, mask;

  always_comb begin
    mask = (ONE << div_shift(sel)) - ONE;
    tick = (sel != 3'd0) && ((div_q & mask) == mask);
    if (restart)            div_d = '0;
    else if (sel != 3'd0)   div_d = div_q + ONE;
    else                    div_d = div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3

endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             match
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    match = (cnt_q == cmp_val);
    if (load)       cnt_d = load_val;
    else if (match) cnt_d = '0;
    else if (tick)  cnt_d = cnt_q + 1'b1;
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !load) |=> (cnt_q == '0)); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !match) |=> $stable(cnt_q)); // R3
  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !match) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R4

endmodule

// File: rtl/rfsh_sequencer.sv
module rfsh_sequencer
  import sdram_refresh_pkg::*;
#(
  parameter int REF_FIX_CYC = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       self_req,
  input  logic       auto_req,
  input  logic       bus_idle,
  input  logic [2:0] ras_cyc,
  input  logic [2:0] row_cyc,
  output logic [3:0] cmd,
  output logic       cke,
  output logic       busy,
  output logic       accept
);

  localparam int HOLD_W = $clog2(REF_FIX_CYC + 15);

  seq_state_e        state_q, state_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic [HOLD_W-1:0] lock_len;

  always_comb begin
    lock_len = HOLD_W'(REF_FIX_CYC) + HOLD_W'(ras_cyc) + HOLD_W'(row_cyc);
    state_d  = state_q;
    hold_d   = hold_q;
    accept   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (self_req && bus_idle) begin
          state_d = ST_SR_ENTRY;
        end else if (auto_req && bus_idle) begin
          state_d = ST_LEAD;
          accept  = 1'b1;
        end
      end
      ST_LEAD: state_d = ST_REF;
      ST_REF: begin
        state_d = ST_HOLD;
        hold_d  = lock_len - 1'b1;
      end
      ST_HOLD: begin
        if (hold_q == '0) state_d = ST_IDLE;
        else              hold_d  = hold_q - 1'b1;
      end
      ST_SR_ENTRY: state_d = ST_SR_ACTIVE;
      ST_SR_ACTIVE: begin
        if (!self_req) begin
          if (row_cyc == 3'd0) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_SR_EXIT;
            hold_d  = HOLD_W'(row_cyc) - 1'b1;
          end
        end
      end
      ST_SR_EXIT: begin
        if (hold_q == '0) state_d = ST_IDLE;
        else              hold_d  = hold_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
    end
  end

  always_comb begin
    cmd  = ((state_q == ST_REF) || (state_q == ST_SR_ENTRY)) ? CMD_REF : CMD_NOP;
    cke  = !((state_q == ST_SR_ENTRY) || (state_q == ST_SR_ACTIVE));
    busy = (state_q != ST_IDLE);
  end

  AST_REF_THEN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF && cke) |=> (cmd == CMD_NOP && busy)); // R8
  AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_idle)); // R6
  AST_SR_ENTRY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd == CMD_REF)); // R9
  AST_SR_EXIT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (cmd == CMD_NOP)); // R10

endmodule

// File: rtl/sdram_refresh_ctl.sv
module sdram_refresh_ctl
  import sdram_refresh_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DIV_W       = 12,
  parameter int REF_FIX_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             bus_idle,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic             sd_cke,
  output logic             rfsh_busy
);

  logic             rst_meta_q, rst_sync_q;
  mode_t            mode_q, mode_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [2:0]       sel_q, sel_d;
  logic             pend_q, pend_d;
  logic             wr_mode, wr_cmp, wr_cnt, wr_sel;
  logic             tick, match, accept, auto_en, self_req;
  logic [3:0]       cmd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    wr_mode  = cfg_we && (cfg_addr == ADDR_MODE);
    wr_cmp   = cfg_we && (cfg_addr == ADDR_CMP);
    wr_cnt   = cfg_we && (cfg_addr == ADDR_CNT);
    wr_sel   = cfg_we && (cfg_addr == ADDR_CLK);
    mode_d   = wr_mode ? mode_t'(cfg_wdata[7:0]) : mode_q;
    cmp_d    = wr_cmp  ? cfg_wdata : cmp_q;
    sel_d    = wr_sel  ? cfg_wdata[2:0] : sel_q;
    auto_en  = mode_q.ref_en && !mode_q.self_mode;
    self_req = mode_q.ref_en && mode_q.self_mode;
    if (!auto_en)    pend_d = 1'b0;
    else if (match)  pend_d = 1'b1;
    else if (accept) pend_d = 1'b0;
    else             pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      mode_q <= '0;
      cmp_q  <= '1;
      sel_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cmp_q  <= cmp_d;
      sel_q  <= sel_d;
      pend_q <= pend_d;
    end
  end

  rfsh_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_sync_q), .sel(sel_q), .restart(wr_sel), .tick(tick)
  );

  rfsh_interval #(.CNT_W(CNT_W)) u_intv (
    .clk(clk), .rst_n(rst_sync_q), .tick(tick), .load(wr_cnt),
    .load_val(cfg_wdata), .cmp_val(cmp_q), .match(match)
  );

  rfsh_sequencer #(.REF_FIX_CYC(REF_FIX_CYC)) u_seq (
    .clk(clk), .rst_n(rst_sync_q), .self_req(self_req), .auto_req(pend_q),
    .bus_idle(bus_idle), .ras_cyc(mode_q.ras_cyc), .row_cyc(mode_q.row_cyc),
    .cmd(cmd), .cke(sd_cke), .busy(rfsh_busy), .accept(accept)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  AST_PEND_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !auto_en |=> !pend_q); // R2

endmodule

// File: tb/sdram_refresh_ctl_tb_top.sv
module sdram_refresh_ctl_tb_top;

  localparam int LOCK_FIX = 1;
  localparam int VEC_N    = 7;
  localparam int V_C0 [VEC_N] = '{0, 5, 250, 0, 0, 0, 0};
  localparam int V_CMP[VEC_N] = '{3, 9, 6,   2, 1, 1, 1};
  localparam int V_SEL[VEC_N] = '{1, 1, 1,   2, 3, 4, 7};
  localparam int V_RAS[VEC_N] = '{0, 2, 7,   1, 0, 2, 0};
  localparam int V_ROW[VEC_N] = '{0, 1, 7,   3, 1, 2, 0};

  logic clk, rst_n, cfg_we, bus_idle;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, rfsh_busy;
  int n_chk, n_fail;
  bit done;

  sdram_refresh_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bus_idle(bus_idle), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_cke(sd_cke), .rfsh_busy(rfsh_busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int ratio(input int s);
    case (s)
      1: return 4;     2: return 16;    3: return 64;  4: return 256;
      5: return 1024;  6: return 2048;  7: return 4096;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] cmd_now();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  function automatic bit is_ref();
    return (cmd_now() == 4'b0001) && sd_cke;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; bus_idle = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_ref(output int n, input int limit);
    n = 0;
    while (!is_ref() && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n, hold, first, refs;
    n_chk = 0; n_fail = 0; done = 0;

    // R1: reset state
    do_reset();
    chk(cmd_now() == 4'b0111, "R1", "reset command", int'(cmd_now()), 7);
    chk(sd_cke == 1'b1, "R1", "reset cke", int'(sd_cke), 1);
    chk(rfsh_busy == 1'b0, "R1", "reset busy", int'(rfsh_busy), 0);

    // Vector table: first refresh delay, lockout, period (R3 R4 R5 R7 R8)
    for (int v = 0; v < VEC_N; v++) begin
      do_reset();
      wr(2'd1, 8'(V_CMP[v]));
      wr(2'd2, 8'(V_C0[v]));
      wr(2'd0, {3'(V_ROW[v]), 3'(V_RAS[v]), 1'b0, 1'b1});
      wr(2'd3, 8'(V_SEL[v]));
      first = ratio(V_SEL[v]) * ((V_CMP[v] - V_C0[v]) & 255) + 3;
      wait_ref(n, first + 50);
      chk(n == first, "R4", "cycles to first refresh", n, first);
      chk(rfsh_busy == 1'b1, "R7", "busy on refresh cycle", int'(rfsh_busy), 1);
      hold = LOCK_FIX + V_RAS[v] + V_ROW[v];
      for (int j = 0; j < hold; j++) begin
        @(negedge clk);
        chk(rfsh_busy && cmd_now() == 4'b0111, "R8", "lockout NOP/busy",
            int'({rfsh_busy, cmd_now()}), 5'h17);
      end
      @(negedge clk);
      chk(rfsh_busy == 1'b0, "R8", "busy after lockout", int'(rfsh_busy), 0);
      wait_ref(n, ratio(V_SEL[v]) * V_CMP[v] + 50);
      chk(n + hold + 1 == ratio(V_SEL[v]) * V_CMP[v], "R5", "refresh period",
          n + hold + 1, ratio(V_SEL[v]) * V_CMP[v]);
    end

    // R3: select code 0 keeps the counter stopped
    do_reset();
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h01);
    refs = 0;
    for (int i = 0; i < 200; i++) begin
      if (!(cmd_now() == 4'b0111)) refs++;
      @(negedge clk);
    end
    chk(refs == 0, "R3", "non-NOP cycles with select 0", refs, 0);

    // R2: enable bit clear, timer running
    do_reset();
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'd1);
    refs = 0;
    for (int i = 0; i < 200; i++) begin
      if (!(cmd_now() == 4'b0111) || rfsh_busy) refs++;
      @(negedge clk);
    end
    chk(refs == 0, "R2", "activity with refresh disabled", refs, 0);

    // R6: bus held busy over three matches, then released
    do_reset();
    wr(2'd1, 8'd20);
    wr(2'd0, 8'h01);
    bus_idle = 1'b0;
    wr(2'd3, 8'd1);
    refs = 0;
    for (int i = 0; i < 250; i++) begin
      if (rfsh_busy || !(cmd_now() == 4'b0111)) refs++;
      @(negedge clk);
    end
    chk(refs == 0, "R6", "activity while bus not idle", refs, 0);
    bus_idle = 1'b1;
    wait_ref(n, 50);
    chk(n == 2, "R6", "cycles from idle to refresh", n, 2);
    refs = 0;
    for (int i = 0; i < 58; i++) begin
      @(negedge clk);
      if (is_ref()) refs++;
    end
    chk(refs == 0, "R6", "extra queued refreshes", refs, 0);

    // R9/R10: self-refresh entry and exit with row count 3
    do_reset();
    wr(2'd0, 8'h63);
    @(negedge clk);
    chk(cmd_now() == 4'b0001 && !sd_cke, "R9", "entry REF with CKE low",
        int'({sd_cke, cmd_now()}), 1);
    refs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sd_cke || !rfsh_busy || cmd_now() != 4'b0111) refs++;
    end
    chk(refs == 0, "R9", "cycles off self-refresh hold", refs, 0);
    wr(2'd0, 8'h61);
    chk(!sd_cke, "R10", "CKE still low in write cycle", int'(sd_cke), 0);
    n = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (sd_cke && rfsh_busy && cmd_now() == 4'b0111) n++;
    end
    chk(n == 3, "R10", "exit NOP cycles with CKE high", n, 3);
    @(negedge clk);
    chk(!rfsh_busy && sd_cke, "R10", "ready after exit",
        int'({rfsh_busy, sd_cke}), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule